// File: doc/BRIEF.md
# System Control Register Bank

A bank of control and status words on a plain 32-bit register bus inside a 4 KB address window. Software uses it to hold two general configuration words and to drive a set of board indicator lights from one of them. It also exposes a read-only switch word, three read-only identification words fixed at build time, and a clock-lock status word.

The clock-lock word combines live lock indications from up to eight clock-generation loops with an 8-bit mask that software can write. The summary bit in that word is recomputed on every read: it shows whether every loop selected by the mask is locked. Loops left out of the mask are ignored, so software can exclude generators that it does not use.

Reads return data one cycle after the read strobe. Accesses to offsets that hold no register are harmless. Each such access also raises a one-cycle flag for verification.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset, CFG0 and CFG1 hold zero, the indicator outputs are low, `bad_access` is low, and with all lock inputs high the lock word reads 0xFFFF0001.
- R2: Offset 0x000 (CFG0) and offset 0x004 (CFG1) each store a full 32-bit write and return it on read.
- R3: Indicator output i equals bit i of CFG1 from the clock edge that accepts the write onward.
- R4: `bus_rdata` carries the addressed word in the cycle after a cycle with `bus_re` high, and is zero in the cycle after a cycle with `bus_re` low.
- R5: Offset 0x00C (switches) always reads zero, and writes to it have no effect.
- R6: Offsets 0x010, 0xFF8 and 0xFFC return the parameters `INFO_VAL`, `AUX_ID_VAL` and `ID_VAL` (default zero), and writes to them have no effect.
- R7: At offset 0x100 (lock word), a write stores only bits 31:24 as the lock mask. The mask resets to 0xFF.
- R8: Lock-word bits 23:16 show the lock inputs as sampled at the read edge, and bits 15:1 read zero. Positions with no lock input read one.
- R9: Lock-word bit 0 is 1 exactly when every lock input whose mask bit is set is high.
- R10: A read of any other offset, including any offset that is not 4-byte aligned, returns zero. A write to such an offset changes no register.
- R11: `bad_access` is high for exactly the cycle after each read or write to an unmapped offset. It stays low for accesses to mapped offsets, read-only ones included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte offset within the window |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| dll_locked | input | NUM_DLL | Per-loop lock indications |
| led | output | NUM_LEDS | Indicator outputs from CFG1 |
| bad_access | output | 1 | One-cycle flag for an unmapped access |

## Verification
The bench builds the bank with four indicator outputs and eight lock inputs. This shows that the upper CFG1 bits are stored and read back but drive no output. The three identification parameters are set to distinct non-zero patterns, so a swapped or tied-off read-only word cannot pass as the zero default. With all eight lock inputs present, every mask bit can be tested against a live input. The bench therefore walks mask and lock patterns that flip the summary bit in both directions.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int LOCK_W   = 8;
    localparam int MASK_LSB = 24;
    localparam int STAT_LSB = 16;

    typedef enum logic [2:0] {
        RID_CFG0   = 3'd0,
        RID_CFG1   = 3'd1,
        RID_SWITCH = 3'd2,
        RID_INFO   = 3'd3,
        RID_LOCK   = 3'd4,
        RID_AUXID  = 3'd5,
        RID_ID     = 3'd6
    } reg_id_e;

    localparam int NUM_REGS = 7;

    function automatic logic [ADDR_W-1:0] reg_offset(input int idx);
        logic [ADDR_W-1:0] off;
        case (idx)
            0:       off = 12'h000;
            1:       off = 12'h004;
            2:       off = 12'h00C;
            3:       off = 12'h010;
            4:       off = 12'h100;
            5:       off = 12'hFF8;
            default: off = 12'hFFC;
        endcase
        return off;
    endfunction

    typedef struct packed {
        logic [DATA_W-1:0] cfg0;
        logic [DATA_W-1:0] cfg1;
        logic [LOCK_W-1:0] lock_mask;
        logic [DATA_W-1:0] rdata;
        logic              bad;
    } bank_t;

endpackage

// File: rtl/sysctl_addr_decode.sv
module sysctl_addr_decode
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_REGS-1:0] sel,
    output logic              miss
);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_match
        assign sel[i] = (addr == reg_offset(i));
    end

    assign miss = ~|sel;

    // R10
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel) && (miss == (sel == '0)));

endmodule

// File: rtl/sysctl_lock_stat.sv
module sysctl_lock_stat
    import sysctl_pkg::*;
#(
    parameter int NUM_DLL = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LOCK_W-1:0]  mask,
    input  logic [NUM_DLL-1:0] locked,
    output logic [DATA_W-1:0]  word
);

    localparam int PAD_W = STAT_LSB - 1;

    logic [LOCK_W-1:0] lk;
    logic [LOCK_W-1:0] ok;

    for (genvar i = 0; i < LOCK_W; i++) begin : g_loop
        if (i < NUM_DLL) begin : g_live
            assign lk[i] = locked[i];
        end else begin : g_tied
            assign lk[i] = 1'b1;
        end
        assign ok[i] = ~mask[i] | lk[i];
    end

    assign word = {mask, lk, {PAD_W{1'b0}}, &ok};

    // R9
    all_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&lk) |-> word[0]);

    // R9
    nothing_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> word[0]);

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter int          NUM_LEDS   = 8,
    parameter int          NUM_DLL    = 8,
    parameter logic [31:0] INFO_VAL   = 32'h0,
    parameter logic [31:0] AUX_ID_VAL = 32'h0,
    parameter logic [31:0] ID_VAL     = 32'h0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [11:0]        bus_addr,
    input  logic               bus_we,
    input  logic               bus_re,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_DLL-1:0] dll_locked,
    output logic [NUM_LEDS-1:0] led,
    output logic               bad_access
);

    localparam bank_t RESET_BANK = '{
        cfg0:      '0,
        cfg1:      '0,
        lock_mask: '1,
        rdata:     '0,
        bad:       1'b0
    };

    bank_t               bank_d, bank_q;
    logic [NUM_REGS-1:0] sel;
    logic                miss;
    logic [DATA_W-1:0]   lock_word;
    logic [DATA_W-1:0]   rd_word;

    sysctl_addr_decode u_decode (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (bus_addr),
        .sel   (sel),
        .miss  (miss)
    );

    sysctl_lock_stat #(.NUM_DLL(NUM_DLL)) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .mask   (bank_q.lock_mask),
        .locked (dll_locked),
        .word   (lock_word)
    );

    always_comb begin
        rd_word = '0;
        if (sel[int'(RID_CFG0)])   rd_word = bank_q.cfg0;
        if (sel[int'(RID_CFG1)])   rd_word = bank_q.cfg1;
        if (sel[int'(RID_SWITCH)]) rd_word = '0;
        if (sel[int'(RID_INFO)])   rd_word = INFO_VAL;
        if (sel[int'(RID_LOCK)])   rd_word = lock_word;
        if (sel[int'(RID_AUXID)])  rd_word = AUX_ID_VAL;
        if (sel[int'(RID_ID)])     rd_word = ID_VAL;
    end

    always_comb begin
        bank_d       = bank_q;
        bank_d.rdata = bus_re ? rd_word : '0;
        bank_d.bad   = (bus_re | bus_we) & miss;
        if (bus_we) begin
            if (sel[int'(RID_CFG0)]) bank_d.cfg0 = bus_wdata;
            if (sel[int'(RID_CFG1)]) bank_d.cfg1 = bus_wdata;
            if (sel[int'(RID_LOCK)]) bank_d.lock_mask = bus_wdata[DATA_W-1:MASK_LSB];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= RESET_BANK;
        else        bank_q <= bank_d;
    end

    assign bus_rdata  = bank_q.rdata;
    assign bad_access = bank_q.bad;
    assign led        = bank_q.cfg1[NUM_LEDS-1:0];

    // R3
    led_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel[int'(RID_CFG1)]) |=> (led == $past(bus_wdata[NUM_LEDS-1:0])));

    // R4
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> (bus_rdata == '0));

    // R7
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && sel[int'(RID_LOCK)]) |=> $stable(bank_q.lock_mask));

    // R10
    stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && miss) |=> ($stable(bank_q.cfg0) && $stable(bank_q.cfg1)
                              && $stable(bank_q.lock_mask)));

    // R11
    bad_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_access |-> $past(bus_re || bus_we));

endmodule

// File: tb/sysctl_regbank_test.sv
module sysctl_regbank_test;

    localparam logic [31:0] INFO = 32'h1357_9BDF;
    localparam logic [31:0] AUX  = 32'h2468_ACE0;
    localparam logic [31:0] IDV  = 32'h0BAD_F00D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  locks = 8'hFF;
    logic [3:0]  led;
    logic        bad_access;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_cfg0 = '0;
    logic [31:0] m_cfg1 = '0;
    logic [7:0]  m_mask = 8'hFF;

    always #4 clk = ~clk;

    sysctl_regbank #(
        .NUM_LEDS(4), .NUM_DLL(8),
        .INFO_VAL(INFO), .AUX_ID_VAL(AUX), .ID_VAL(IDV)
    ) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dll_locked(locks), .led(led), .bad_access(bad_access)
    );

    function automatic bit is_mapped(input logic [11:0] a);
        return a == 12'h000 || a == 12'h004 || a == 12'h00C || a == 12'h010 ||
               a == 12'h100 || a == 12'hFF8 || a == 12'hFFC;
    endfunction

    function automatic logic [31:0] model_read(input logic [11:0] a);
        logic summ;
        summ = 1'b1;
        for (int k = 0; k < 8; k++)
            if (m_mask[k] && !locks[k]) summ = 1'b0;
        case (a)
            12'h000: return m_cfg0;
            12'h004: return m_cfg1;
            12'h010: return INFO;
            12'h100: return {m_mask, locks, 15'h0, summ};
            12'hFF8: return AUX;
            12'hFFC: return IDV;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic re, input logic we, input logic [11:0] a,
                        input logic [31:0] d, input string tag);
        logic [31:0] exp_rd;
        logic        exp_bad;
        bus_re = re; bus_we = we; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        exp_rd  = re ? model_read(a) : 32'h0;
        exp_bad = (re || we) && !is_mapped(a);
        if (we) begin
            case (a)
                12'h000: m_cfg0 = d;
                12'h004: m_cfg1 = d;
                12'h100: m_mask = d[31:24];
                default: ;
            endcase
        end
        #2;
        check(bus_rdata, exp_rd, tag);
        check({28'h0, led}, {28'h0, m_cfg1[3:0]}, "R3 led");
        check({31'h0, bad_access}, {31'h0, exp_bad}, "R11 bad_access");
        @(negedge clk);
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        step(1'b1, 1'b0, a, 32'h0, tag);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
        step(1'b0, 1'b1, a, d, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs while in reset
        check(bus_rdata, 32'h0, "R1 rdata");
        check({31'h0, bad_access}, 32'h0, "R1 bad");
        check({28'h0, led}, 32'h0, "R1 led");
        rst_n = 1'b1;
        step(1'b0, 1'b0, 12'h000, 32'h0, "R1 idle");
        rd(12'h100, "R1 lock reset");
        rd(12'h000, "R1 cfg0");
        rd(12'h004, "R1 cfg1");

        wr(12'h000, 32'hDEAD_BEEF, "R2 write cfg0");
        rd(12'h000, "R2 cfg0");
        wr(12'h004, 32'hA5A5_0005, "R3 write cfg1");
        rd(12'h004, "R2 cfg1");
        wr(12'h004, 32'h0000_000A, "R3 write cfg1");
        step(1'b0, 1'b0, 12'h004, 32'h0, "R4 idle after read");
        rd(12'h000, "R4 read");
        step(1'b0, 1'b0, 12'h000, 32'h0, "R4 idle");

        wr(12'h00C, 32'hFFFF_FFFF, "R5 write switch");
        rd(12'h00C, "R5 switch");

        rd(12'h010, "R6 info");
        rd(12'hFF8, "R6 aux");
        rd(12'hFFC, "R6 id");
        wr(12'h010, 32'h1111_1111, "R6 write info");
        wr(12'hFF8, 32'h2222_2222, "R6 write aux");
        wr(12'hFFC, 32'h3333_3333, "R6 write id");
        rd(12'h010, "R6 info after write");
        rd(12'hFF8, "R6 aux after write");
        rd(12'hFFC, "R6 id after write");

        wr(12'h100, 32'h1234_5678, "R7 write lock");
        rd(12'h100, "R7 mask");
        locks = 8'h0F;
        rd(12'h100, "R9 masked loop unlocked");
        wr(12'h100, 32'h0F00_0000, "R7 write lock");
        rd(12'h100, "R9 all masked locked");
        locks = 8'hA5;
        rd(12'h100, "R8 live lock bits");
        wr(12'h100, 32'h0000_FFFF, "R7 write lock");
        locks = 8'h00;
        rd(12'h100, "R9 empty mask");
        wr(12'h100, 32'h8000_0000, "R7 write lock");
        locks = 8'h7F;
        rd(12'h100, "R9 top loop");
        locks = 8'h80;
        rd(12'h100, "R9 top loop locked");
        locks = 8'hFF;

        rd(12'h008, "R10 gap");
        rd(12'h200, "R10 mid window");
        rd(12'h001, "R10 unaligned");
        rd(12'hFF4, "R10 below id");
        wr(12'h008, 32'h5555_5555, "R10 stray write");
        wr(12'h005, 32'h6666_6666, "R10 unaligned write");
        wr(12'h104, 32'hFFFF_FFFF, "R10 stray write");
        rd(12'h000, "R10 cfg0 kept");
        rd(12'h004, "R10 cfg1 kept");
        rd(12'h100, "R10 lock kept");
        rd(12'h300, "R11 back to back a");
        rd(12'h304, "R11 back to back b");
        step(1'b0, 1'b0, 12'h300, 32'h0, "R11 idle after miss");

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule